// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Model

This block is a synthesizable behavioural model of a synchronous static RAM with registered inputs, a pipelined registered read path and a short internal burst sequencer. Every control and data input is captured on the rising clock edge. A burst begins when one of two address strobes loads an external address. The strobe driven by the memory controller honours the write enables. The strobe driven by the processor always starts a read. After that, an advance input walks through the remaining three words of the aligned group of four. The walk is either linear or interleaved, chosen by a mode input.

Writes are layered. A global write stores every byte lane. Otherwise, a master byte-write enable stores only the lanes whose own enables are high. A write beat produces no output. Read data leaves through an output register, and the output drive is gated asynchronously by an output enable. When the output is not driven, the data reads as zero and the valid flag is low; this models high impedance. A sleep input blocks every new beat while it is high and leaves the array untouched. The default build has 64 words of four 8-bit lanes.

Top module: `burst_sram_model`

## Requirements
- R1: In linear mode (`order_il`=0), beat n of a burst started at address A reads or writes address A with its two low bits replaced by (A[1:0]+n) mod 4. The upper bits stay fixed.
- R2: In interleaved mode (`order_il`=1), beat n uses low bits A[1:0] XOR n. The upper bits stay fixed.
- R3: A read beat sampled at rising edge k drives `rdata_vld`=1 with the addressed word after edge k+2. Beats sampled at consecutive edges produce data on consecutive cycles, which gives the 3-1-1-1 pattern.
- R4: Either strobe, taken with all chip enables active, loads `addr` and restarts the burst at beat 0. A beat started by `cpu_strobe` alone is always a read, whatever the write enables are.
- R5: `cpu_strobe` is ignored while `sel_main`=0. It starts no beat, and a running burst keeps advancing if `advance` is high in that cycle.
- R6: When both strobes are high in the same cycle, the controller strobe decides the beat, so the write enables are honoured.
- R7: `write_all`=1 writes all four lanes. Otherwise `byte_wr_master`=1 writes the lanes whose `byte_en` bit is 1; lane i is `wdata[8i+7:8i]`. A beat with no lane selected is a read. A write beat never raises `rdata_vld`.
- R8: A strobe taken while the chip is not selected (`sel_main`=0, `sel_hi`=0 or `sel_lo_n`=1) starts no beat and ends the running burst. `rdata_vld` is low two edges later, and a later `advance` does nothing.
- R9: While `out_en`=0, `rdata` is zero and `rdata_vld` is low in the same cycle. The registered word reappears as soon as `out_en` returns high.
- R10: While `sleep`=1, no strobe or advance starts a beat and no word is written. The burst position is kept, so advancing resumes after sleep is released.
- R11: `advance` with no running burst starts nothing. A burst keeps cycling through the same four addresses after its fourth beat.
- R12: During and right after reset, `rdata_vld` is low and no burst is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | External word address loaded by a strobe |
| wdata | input | NBYTES*BYTE_W | Write data, captured with each beat |
| sel_main | input | 1 | Primary chip enable, active high |
| sel_hi | input | 1 | Depth-expansion enable, active high |
| sel_lo_n | input | 1 | Depth-expansion enable, active low |
| cpu_strobe | input | 1 | Processor address strobe (read start) |
| ctl_strobe | input | 1 | Controller address strobe (read or write start) |
| advance | input | 1 | Step the burst to its next beat |
| write_all | input | 1 | Global write of every lane |
| byte_wr_master | input | 1 | Enables the per-lane write selects |
| byte_en | input | NBYTES | Per-lane write selects |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en | input | 1 | Asynchronous output drive enable |
| sleep | input | 1 | Blocks new beats while high |
| rdata | output | NBYTES*BYTE_W | Read data (zero when not driven) |
| rdata_vld | output | 1 | Read data is driven and valid |

## Verification
The hardest states to reach are the ones where a burst is in flight and something interrupts its progress. Examples are a strobe that is ignored or overruled, a deselect, a sleep window, or an output-enable drop that lands on the exact cycle a registered word emerges. The stimulus drives one cycle at a time and changes control inputs mid-burst. A model in the bench tracks the burst position and the expected output cycle under the stated rules. That lets the bench predict, three edges ahead, whether each cycle should show a word, which word, or nothing.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    // Kind of array access issued in a given cycle.
    typedef enum logic [1:0] {
        BEAT_NONE  = 2'd0,
        BEAT_READ  = 2'd1,
        BEAT_WRITE = 2'd2
    } beat_kind_e;

    // Low two address bits for a beat: linear adds, interleaved XORs.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input logic       interleaved);
        return interleaved ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/bsram_burst_seq.sv
module bsram_burst_seq
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_main,
    input  logic              sel_hi,
    input  logic              sel_lo_n,
    input  logic              cpu_strobe,
    input  logic              ctl_strobe,
    input  logic              advance,
    input  logic              write_all,
    input  logic              byte_wr_master,
    input  logic [NBYTES-1:0] byte_en,
    input  logic              order_il,
    input  logic              sleep,
    output beat_kind_e        beat_kind,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [NBYTES-1:0] beat_mask
);

    logic              live_q;
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;

    logic              chip_on;
    logic              strobe_hit;
    logic              step_hit;
    logic [1:0]        cnt_nxt;
    logic [NBYTES-1:0] wr_mask;

    always_comb begin
        chip_on    = sel_main & sel_hi & ~sel_lo_n;
        // processor strobe only counts with the primary enable active
        strobe_hit = ~sleep & (ctl_strobe | (cpu_strobe & sel_main));
        step_hit   = ~sleep & ~strobe_hit & advance & live_q;
        cnt_nxt    = cnt_q + 2'd1;
        wr_mask    = write_all ? {NBYTES{1'b1}} : (byte_wr_master ? byte_en : '0);

        beat_kind = BEAT_NONE;
        beat_addr = addr;
        beat_mask = wr_mask;
        if (strobe_hit && chip_on) begin
            // controller strobe wins a tie and is the only one that writes
            beat_kind = (ctl_strobe && (|wr_mask)) ? BEAT_WRITE : BEAT_READ;
        end else if (step_hit) begin
            beat_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_nxt, order_il)};
            beat_kind = (|wr_mask) ? BEAT_WRITE : BEAT_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= 1'b0;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (strobe_hit) begin
            live_q <= chip_on;
            if (chip_on) begin
                base_q <= addr;
                cnt_q  <= 2'd0;
            end
        end else if (step_hit) begin
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/bsram_array.sv
module bsram_array
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  beat_kind_e               kind,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES-1:0]        mask,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    output logic [NBYTES*BYTE_W-1:0] rd_data,
    output logic                     rd_vld
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] cells [DEPTH];
        logic [BYTE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (kind == BEAT_WRITE && mask[b]) begin
                cells[addr] <= wdata[b*BYTE_W +: BYTE_W];
            end
            if (kind == BEAT_READ) begin
                lane_q <= cells[addr];
            end
        end

        assign rd_data[b*BYTE_W +: BYTE_W] = lane_q;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_vld <= 1'b0;
        else     rd_vld <= (kind == BEAT_READ);
    end

endmodule

// File: rtl/bsram_out_stage.sv
module bsram_out_stage #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_vld,
    input  logic              out_en,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld
);

    logic [DATA_W-1:0] data_q;
    logic              vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            data_q <= in_data;
            vld_q  <= in_vld;
        end
    end

    // drive gate is combinational: no clock involved
    assign rdata     = out_en ? data_q : '0;
    assign rdata_vld = out_en & vld_q;

endmodule

// File: rtl/burst_sram_model.sv
module burst_sram_model
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    input  logic                     sel_main,
    input  logic                     sel_hi,
    input  logic                     sel_lo_n,
    input  logic                     cpu_strobe,
    input  logic                     ctl_strobe,
    input  logic                     advance,
    input  logic                     write_all,
    input  logic                     byte_wr_master,
    input  logic [NBYTES-1:0]        byte_en,
    input  logic                     order_il,
    input  logic                     out_en,
    input  logic                     sleep,
    output logic [NBYTES*BYTE_W-1:0] rdata,
    output logic                     rdata_vld
);

    localparam int DATA_W = NBYTES * BYTE_W;

    typedef struct packed {
        beat_kind_e        kind;
        logic [ADDR_W-1:0] addr;
        logic [NBYTES-1:0] mask;
        logic [DATA_W-1:0] wdata;
    } stage_t;

    beat_kind_e        seq_kind;
    logic [ADDR_W-1:0] seq_addr;
    logic [NBYTES-1:0] seq_mask;
    stage_t            in_q;
    logic [DATA_W-1:0] arr_data;
    logic              arr_vld;

    bsram_burst_seq #(
        .ADDR_W(ADDR_W),
        .NBYTES(NBYTES)
    ) i_seq (
        .clk           (clk),
        .rst           (rst),
        .addr          (addr),
        .sel_main      (sel_main),
        .sel_hi        (sel_hi),
        .sel_lo_n      (sel_lo_n),
        .cpu_strobe    (cpu_strobe),
        .ctl_strobe    (ctl_strobe),
        .advance       (advance),
        .write_all     (write_all),
        .byte_wr_master(byte_wr_master),
        .byte_en       (byte_en),
        .order_il      (order_il),
        .sleep         (sleep),
        .beat_kind     (seq_kind),
        .beat_addr     (seq_addr),
        .beat_mask     (seq_mask)
    );

    // input register stage
    always_ff @(posedge clk) begin
        if (rst) begin
            in_q <= '{kind: BEAT_NONE, addr: '0, mask: '0, wdata: '0};
        end else begin
            in_q <= '{kind: seq_kind, addr: seq_addr, mask: seq_mask, wdata: wdata};
        end
    end

    bsram_array #(
        .ADDR_W(ADDR_W),
        .NBYTES(NBYTES),
        .BYTE_W(BYTE_W)
    ) i_array (
        .clk    (clk),
        .rst    (rst),
        .kind   (in_q.kind),
        .addr   (in_q.addr),
        .mask   (in_q.mask),
        .wdata  (in_q.wdata),
        .rd_data(arr_data),
        .rd_vld (arr_vld)
    );

    bsram_out_stage #(
        .DATA_W(DATA_W)
    ) i_out (
        .clk      (clk),
        .rst      (rst),
        .in_data  (arr_data),
        .in_vld   (arr_vld),
        .out_en   (out_en),
        .rdata    (rdata),
        .rdata_vld(rdata_vld)
    );

endmodule

// File: rtl/bsram_checker.sv
module bsram_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_main,
    input logic              sel_hi,
    input logic              sel_lo_n,
    input logic              cpu_strobe,
    input logic              ctl_strobe,
    input logic              advance,
    input logic              write_all,
    input logic              byte_wr_master,
    input logic              out_en,
    input logic              sleep,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_vld
);

    logic chip_on;
    assign chip_on = sel_main & sel_hi & ~sel_lo_n;

    // R3: a plain read started by the controller strobe shows up after two more edges
    a_r3_read_latency: assert property (@(posedge clk) disable iff (rst)
        (ctl_strobe && chip_on && !sleep && !write_all && !byte_wr_master)
        |-> ##3 (rdata_vld || !out_en));

    // R7: a global write by the controller strobe produces no output word
    a_r7_write_silent: assert property (@(posedge clk) disable iff (rst)
        (ctl_strobe && chip_on && !sleep && write_all)
        |-> ##3 !rdata_vld);

    // R8: a deselecting strobe issues nothing
    a_r8_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
        (ctl_strobe && !chip_on && !sleep)
        |-> ##3 !rdata_vld);

    // R5: processor strobe without the primary enable issues nothing
    a_r5_cpu_ignored: assert property (@(posedge clk) disable iff (rst)
        (cpu_strobe && !sel_main && !ctl_strobe && !advance)
        |-> ##3 !rdata_vld);

    // R10: no beat is issued in a sleep cycle
    a_r10_sleep_blocks: assert property (@(posedge clk) disable iff (rst)
        sleep |-> ##3 !rdata_vld);

    // R9: undriven output reads as zero
    a_r9_undriven_zero: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (rdata == '0 && !rdata_vld));

endmodule

bind burst_sram_model bsram_checker #(
    .DATA_W(NBYTES * BYTE_W)
) i_bsram_checker (
    .clk           (clk),
    .rst           (rst),
    .sel_main      (sel_main),
    .sel_hi        (sel_hi),
    .sel_lo_n      (sel_lo_n),
    .cpu_strobe    (cpu_strobe),
    .ctl_strobe    (ctl_strobe),
    .advance       (advance),
    .write_all     (write_all),
    .byte_wr_master(byte_wr_master),
    .out_en        (out_en),
    .sleep         (sleep),
    .rdata         (rdata),
    .rdata_vld     (rdata_vld)
);

// File: tb/test_burst_sram_model.sv
`timescale 1ns/1ps
module test_burst_sram_model;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  addr;
    logic [31:0] wdata;
    logic        sel_main, sel_hi, sel_lo_n;
    logic        cpu_strobe, ctl_strobe, advance;
    logic        write_all, byte_wr_master;
    logic [3:0]  byte_en;
    logic        order_il, out_en, sleep;
    logic [31:0] rdata;
    logic        rdata_vld;

    always #2.5 clk = ~clk;

    burst_sram_model i_burst_sram_model (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .sel_main(sel_main), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .cpu_strobe(cpu_strobe), .ctl_strobe(ctl_strobe), .advance(advance),
        .write_all(write_all), .byte_wr_master(byte_wr_master), .byte_en(byte_en),
        .order_il(order_il), .out_en(out_en), .sleep(sleep),
        .rdata(rdata), .rdata_vld(rdata_vld)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit chk_on = 0;
    bit done   = 0;

    logic [31:0] shadow   [64];
    logic        exp_vld  [8];
    logic [31:0] exp_data [8];
    string       exp_tag  [8];

    // bench burst model
    logic       bl_live = 0;
    logic [5:0] bl_base = '0;
    logic [1:0] bl_beat = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // per-cycle output comparison, away from the clock edge
    always @(negedge clk) begin
        int s;
        #1;
        if (chk_on) begin
            s = cyc % 8;
            if (!out_en) begin
                check(!rdata_vld && rdata == 32'h0, "R9", {rdata[31:1], rdata_vld}, 32'h0);
            end else if (exp_vld[s]) begin
                check(rdata_vld === 1'b1, exp_tag[s], {31'h0, rdata_vld}, 32'h1);
                check(rdata === exp_data[s], exp_tag[s], rdata, exp_data[s]);
            end else begin
                check(rdata_vld === 1'b0, exp_tag[s], {31'h0, rdata_vld}, 32'h0);
            end
            exp_vld[s] = 1'b0;
            exp_tag[s] = "R12";
        end
    end

    task automatic rest();
        cpu_strobe = 0; ctl_strobe = 0; advance = 0;
        write_all = 0; byte_wr_master = 0; byte_en = 4'h0;
    endtask

    // one clock of stimulus; predicts the output three edges ahead
    task automatic tick(input string tag);
        logic       on, go, wr;
        logic [5:0] a;
        logic [3:0] m;
        int         s;
        on = sel_main && sel_hi && !sel_lo_n;
        m  = write_all ? 4'hF : (byte_wr_master ? byte_en : 4'h0);
        go = 0; wr = 0; a = addr;
        if (!sleep && (ctl_strobe || (cpu_strobe && sel_main))) begin
            if (on) begin
                bl_live = 1; bl_base = addr; bl_beat = 0;
                a = addr; go = 1; wr = ctl_strobe && (m != 0);
            end else begin
                bl_live = 0;
            end
        end else if (!sleep && advance && bl_live) begin
            bl_beat = bl_beat + 2'd1;
            a  = {bl_base[5:2], order_il ? (bl_base[1:0] ^ bl_beat) : (bl_base[1:0] + bl_beat)};
            go = 1; wr = (m != 0);
        end
        s = (cyc + 3) % 8;
        exp_tag[s] = tag;
        exp_vld[s] = 1'b0;
        if (go && wr) begin
            for (int b = 0; b < 4; b++)
                if (m[b]) shadow[a][b*8 +: 8] = wdata[b*8 +: 8];
        end else if (go) begin
            exp_vld[s]  = 1'b1;
            exp_data[s] = shadow[a];
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        rest();
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic t_reset();
        rst = 1; addr = '0; wdata = '0; sel_main = 1; sel_hi = 1; sel_lo_n = 0;
        order_il = 0; out_en = 1; sleep = 0; rest();
        for (int i = 0; i < 8; i++) begin exp_vld[i] = 0; exp_tag[i] = "R12"; end
        repeat (3) @(negedge clk);
        check(rdata_vld === 1'b0, "R12", {31'h0, rdata_vld}, 32'h0);
        rst = 0;
        chk_on = 1;
        idle(3, "R12");
        // advance with no running burst
        advance = 1; tick("R11"); tick("R11"); rest();
        idle(3, "R11");
    endtask

    task automatic t_fill();
        for (int w = 0; w < 16; w++) begin
            rest(); ctl_strobe = 1; write_all = 1; addr = 6'(w);
            wdata = 32'hA500_0000 | (w * 32'h0001_0203);
            tick("R7");
        end
        // write burst 16..19 in linear order starting at offset 2
        rest(); order_il = 0; ctl_strobe = 1; write_all = 1; addr = 6'd18; wdata = 32'h1111_0018;
        tick("R4");
        for (int i = 1; i < 4; i++) begin
            rest(); advance = 1; write_all = 1; wdata = 32'h1111_0100 + 32'(i);
            tick("R1");
        end
        idle(4, "R7");
    endtask

    task automatic t_bursts();
        for (int il = 0; il < 2; il++) begin
            for (int st = 0; st < 4; st++) begin
                rest(); order_il = il[0];
                if (st[0]) cpu_strobe = 1; else ctl_strobe = 1;
                addr = 6'(4 + st);
                tick("R4");
                for (int i = 1; i < 4; i++) begin
                    rest(); advance = 1;
                    tick(il != 0 ? "R2" : "R1");
                end
            end
        end
        // back to back reads of the written burst group
        rest(); order_il = 0; ctl_strobe = 1; addr = 6'd16; tick("R3");
        for (int i = 1; i < 4; i++) begin rest(); advance = 1; tick("R3"); end
        idle(4, "R3");
    endtask

    task automatic t_bytes();
        rest(); ctl_strobe = 1; byte_wr_master = 1; byte_en = 4'b0101; addr = 6'd8;
        wdata = 32'hDEAD_BEEF; tick("R7");
        rest(); ctl_strobe = 1; byte_wr_master = 1; byte_en = 4'b1010; addr = 6'd9;
        wdata = 32'hCAFE_F00D; tick("R7");
        rest(); ctl_strobe = 1; byte_wr_master = 1; byte_en = 4'b0000; addr = 6'd10;
        wdata = 32'h0BAD_0BAD; tick("R7");
        rest(); ctl_strobe = 1; write_all = 1; byte_en = 4'b0000; addr = 6'd11;
        wdata = 32'h7777_1234; tick("R7");
        // mixed burst: read start, then per-lane writes on advance
        rest(); ctl_strobe = 1; addr = 6'd12; tick("R7");
        rest(); advance = 1; byte_wr_master = 1; byte_en = 4'b1000; wdata = 32'h5A00_0000; tick("R7");
        rest(); advance = 1; tick("R7");
        // cpu strobe ignores write enables
        rest(); cpu_strobe = 1; write_all = 1; addr = 6'd13; wdata = 32'hFFFF_FFFF; tick("R4");
        idle(3, "R7");
        rest(); ctl_strobe = 1; addr = 6'd8; tick("R7");
        for (int i = 1; i < 8; i++) begin rest(); advance = 1; tick("R7"); end
        idle(4, "R7");
    endtask

    task automatic t_cpu_ignored();
        rest(); order_il = 0; ctl_strobe = 1; addr = 6'd0; tick("R5");
        rest(); advance = 1; tick("R5");
        sel_main = 0;
        rest(); cpu_strobe = 1; advance = 1; addr = 6'd12; tick("R5");
        rest(); cpu_strobe = 1; addr = 6'd12; tick("R5");
        sel_main = 1;
        rest(); advance = 1; tick("R5");
        idle(4, "R5");
    endtask

    task automatic t_priority();
        rest(); cpu_strobe = 1; ctl_strobe = 1; write_all = 1; addr = 6'd14;
        wdata = 32'h6060_6060; tick("R6");
        rest(); cpu_strobe = 1; ctl_strobe = 1; byte_wr_master = 1; byte_en = 4'b0010;
        addr = 6'd15; wdata = 32'h0000_AB00; tick("R6");
        idle(3, "R6");
        rest(); ctl_strobe = 1; addr = 6'd14; tick("R6");
        rest(); advance = 1; tick("R6");
        idle(4, "R6");
    endtask

    task automatic t_deselect();
        rest(); ctl_strobe = 1; addr = 6'd4; tick("R8");
        sel_hi = 0;
        rest(); ctl_strobe = 1; addr = 6'd5; tick("R8");
        sel_hi = 1;
        rest(); advance = 1; tick("R8");
        rest(); advance = 1; tick("R8");
        rest(); cpu_strobe = 1; addr = 6'd6; tick("R8");
        sel_lo_n = 1;
        rest(); cpu_strobe = 1; addr = 6'd7; tick("R8");
        sel_lo_n = 0;
        rest(); advance = 1; tick("R8");
        idle(4, "R8");
    endtask

    task automatic t_out_en();
        rest(); ctl_strobe = 1; addr = 6'd0; tick("R9");
        for (int i = 1; i < 4; i++) begin
            rest(); advance = 1;
            if (i == 3) out_en = 0;
            tick("R9");
        end
        rest(); tick("R9");
        out_en = 1;
        idle(4, "R9");
    endtask

    task automatic t_sleep();
        rest(); order_il = 1; ctl_strobe = 1; addr = 6'd1; tick("R10");
        sleep = 1;
        rest(); advance = 1; tick("R10");
        rest(); ctl_strobe = 1; write_all = 1; addr = 6'd2; wdata = 32'h0; tick("R10");
        sleep = 0;
        rest(); advance = 1; tick("R10");
        rest(); advance = 1; tick("R10");
        rest(); advance = 1; tick("R10");
        idle(3, "R10");
        rest(); ctl_strobe = 1; addr = 6'd2; tick("R10");
        idle(4, "R10");
    endtask

    task automatic t_wrap();
        rest(); order_il = 1; ctl_strobe = 1; addr = 6'd6; tick("R11");
        for (int i = 1; i < 7; i++) begin rest(); advance = 1; tick("R11"); end
        rest(); order_il = 0; ctl_strobe = 1; addr = 6'd19; tick("R11");
        for (int i = 1; i < 6; i++) begin rest(); advance = 1; tick("R11"); end
        idle(5, "R11");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_fill();
        t_bursts();
        t_bytes();
        t_cpu_ignored();
        t_priority();
        t_deselect();
        t_out_en();
        t_sleep();
        t_wrap();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule